// File: doc/BRIEF.md
# Masked End-of-Message Interrupt Generator

This block sits beside the message sequencer of a MIL-STD-1553 terminal. It gathers the completion and fault events of each bus transfer and decides which interrupt conditions belong to that message. It keeps a sticky, host-readable copy of those conditions and applies the host's interrupt enables. When any enabled condition is present, it emits a single active-low pulse. It also raises a halt request for the bus controller when stop-on-error is selected and a message ended with a fault.

Fault indications can arrive in any cycle while a message is in progress. They are accumulated until the end-of-message strobe, and a fault remembered from one message never leaks into the next. There are three conditions: message complete, format error or status set, and block complete. The block-complete condition fires when the current-area message counter reads all ones. The operating mode decides which conditions can fire at all. All control and status pins are plain levels or single-cycle strobes sampled on the rising clock edge. All outputs are registered, so they appear in the cycle that follows the end-of-message strobe.

Top module: `eom_irq_gen`

## Requirements
- R1: While `rst_n` is low and after its release, `irq_n` is 1, `flags` is 0, `cause` is 0 and `halt_req` is 0 until a message ends.
- R2: In bus-controller or remote-terminal mode, every `msg_done` strobe sets `flags[0]` (message complete) at that clock edge, whether or not any fault was seen.
- R3: `flags[1]` (format error / status set) is set at a `msg_done` edge in bus-controller or remote-terminal mode if any `err_vec` bit was high in any cycle since the previous `msg_done`, the strobe cycle included. The `err_vec` bits are: bit 0 loop-back word mismatch, bit 1 validation failure, bit 2 response time-out, bit 3 status bit set or address error.
- R4: `flags[2]` (block complete) is set at a `msg_done` edge only in bus-controller mode and only when `msg_count` is all ones. A count one below all ones, or remote-terminal mode, leaves it clear.
- R5: `mode` encodes 2'b00 bus controller, 2'b01 monitor, 2'b10 remote terminal and 2'b11 reserved. In monitor and reserved modes a `msg_done` sets no flag, no cause bit and no halt request, and it produces no pulse.
- R6: `irq_n` is 0 in the single cycle after a `msg_done` edge exactly when the conditions raised at that edge AND `mask` are non-zero. Mask bit i enables `flags[i]`, and conditions are recorded in `flags` regardless of the mask.
- R7: The low pulse lasts exactly one clock even when several enabled conditions are raised by the same message.
- R8: `flags` and `cause` are sticky. A `flag_rd` strobe clears them at the next edge, except for bits raised by a `msg_done` at that same edge, which read as set.
- R9: `soft_rst` has priority over every event. At the next edge it clears `flags`, `cause`, `halt_req` and the accumulated faults, and it drives `irq_n` high.
- R10: `halt_req` rises at a `msg_done` edge that raises the format condition while `stop_on_err` is 1, regardless of `mask`. It stays high until `stop_on_err` is 0 or `soft_rst` is seen at an edge.
- R11: Faults accumulated before a `msg_done` are discarded at that edge, so a later clean message raises no format condition.
- R12: `cause` ORs in, at each qualifying `msg_done` edge, the `err_vec` bits accumulated for that message, using the bit positions of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous host reset strobe |
| mode | input | 2 | Operating mode (R5 encoding) |
| msg_done | input | 1 | End-of-message strobe, one cycle per message |
| err_vec | input | 4 | Fault strobes (R3 bit order) |
| msg_count | input | CNT_W | Current-area message counter |
| mask | input | 3 | Interrupt enables, one per condition |
| stop_on_err | input | 1 | Halt bus controller on faulted message |
| flag_rd | input | 1 | Host read strobe that clears the sticky flags |
| irq_n | output | 1 | Active-low one-clock interrupt pulse |
| flags | output | 3 | Sticky conditions: 0 complete, 1 format, 2 block |
| cause | output | 4 | Sticky fault sources |
| halt_req | output | 1 | Halt request to the message sequencer |

## Verification
The bench builds the block with `CNT_W` = 6. This makes the all-ones block-complete count (63) and its neighbour (62) cheap to drive, while the comparison logic stays as general as at 16 bits. Every fault source is driven both inside the strobe cycle and earlier in the message. Mask, mode, read-clear and soft-reset collisions are produced in the same cycle as `msg_done`, which reaches the priority corners of R8 and R9.

// File: rtl/eomirq_pkg.sv
package eomirq_pkg;
  localparam int NUM_COND = 3;
  localparam int NUM_ERR  = 4;
  localparam int C_EOM = 0;
  localparam int C_FMT = 1;
  localparam int C_BLK = 2;

  typedef enum logic [1:0] {
    MODE_BC  = 2'b00,
    MODE_MT  = 2'b01,
    MODE_RTU = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;
endpackage

// File: rtl/eomirq_qual.sv
module eomirq_qual
  import eomirq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  mode_e               mode,
  input  logic                msg_done,
  input  logic [NUM_ERR-1:0]  err_vec,
  input  logic [CNT_W-1:0]    msg_count,
  output logic [NUM_COND-1:0] cond,
  output logic [NUM_ERR-1:0]  cause_set
);
  logic [NUM_ERR-1:0] pend_q;
  logic [NUM_ERR-1:0] seen;
  logic               is_bc, active, blk_end;

  // faults accumulate over the message and are dropped at its end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pend_q <= '0;
    else if (soft_rst || msg_done) pend_q <= '0;
    else                           pend_q <= pend_q | err_vec;
  end

  always_comb begin
    seen    = pend_q | err_vec;
    is_bc   = (mode == MODE_BC);
    active  = is_bc || (mode == MODE_RTU);
    blk_end = &msg_count;
    cond          = '0;
    cond[C_EOM]   = msg_done && active;
    cond[C_FMT]   = msg_done && active && (|seen);
    cond[C_BLK]   = msg_done && is_bc && blk_end;
    cause_set     = (msg_done && active) ? seen : '0;
  end
endmodule

// File: rtl/eomirq_flags.sv
module eomirq_flags #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         soft_rst,
  input  logic         rd,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q[i] <= 1'b0;
      else if (soft_rst) q[i] <= 1'b0;
      else if (set[i])   q[i] <= 1'b1;
      else if (rd)       q[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/eomirq_out.sv
module eomirq_out
  import eomirq_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                soft_rst,
  input  logic [NUM_COND-1:0] cond,
  input  logic [NUM_COND-1:0] mask,
  input  logic                stop_on_err,
  output logic                irq_n,
  output logic                halt_req
);
  logic fire;
  assign fire = |(cond & mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_n    <= 1'b1;
      halt_req <= 1'b0;
    end else if (soft_rst) begin
      irq_n    <= 1'b1;
      halt_req <= 1'b0;
    end else begin
      irq_n <= ~fire;
      if (cond[C_FMT] && stop_on_err) halt_req <= 1'b1;
      else if (!stop_on_err)          halt_req <= 1'b0;
    end
  end
endmodule

// File: rtl/eom_irq_gen.sv
module eom_irq_gen
  import eomirq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_rst,
  input  logic [1:0]       mode,
  input  logic             msg_done,
  input  logic [3:0]       err_vec,
  input  logic [CNT_W-1:0] msg_count,
  input  logic [2:0]       mask,
  input  logic             stop_on_err,
  input  logic             flag_rd,
  output logic             irq_n,
  output logic [2:0]       flags,
  output logic [3:0]       cause,
  output logic             halt_req
);
  logic [NUM_COND-1:0] cond;
  logic [NUM_ERR-1:0]  cause_set;

  eomirq_qual #(.CNT_W(CNT_W)) u_qual (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode(mode_e'(mode)),
    .msg_done(msg_done), .err_vec(err_vec), .msg_count(msg_count),
    .cond(cond), .cause_set(cause_set)
  );

  eomirq_flags #(.W(NUM_COND)) u_cond_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd(flag_rd),
    .set(cond), .q(flags)
  );

  eomirq_flags #(.W(NUM_ERR)) u_cause_flags (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rd(flag_rd),
    .set(cause_set), .q(cause)
  );

  eomirq_out u_out (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .cond(cond), .mask(mask),
    .stop_on_err(stop_on_err), .irq_n(irq_n), .halt_req(halt_req)
  );
endmodule

// File: rtl/eomirq_chk.sv
module eomirq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       soft_rst,
  input logic [1:0] mode,
  input logic       msg_done,
  input logic       stop_on_err,
  input logic       irq_n,
  input logic [2:0] flags,
  input logic       halt_req
);
  // R6: a pulse only follows an end-of-message strobe
  p_irq_after_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |-> $past(msg_done));

  // R7: the pulse ends after one clock unless a new message ended
  p_pulse_one_clk_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_n |=> (irq_n || $past(msg_done)));

  // R9: soft reset wins over all events
  p_soft_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (flags == 3'b000 && irq_n && !halt_req));

  // R5: monitor and reserved modes stay silent
  p_mt_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && mode[0] && !soft_rst) |=> irq_n);

  // R2: completion flag after each active-mode message
  p_eom_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done && !mode[0] && !soft_rst) |=> flags[0]);

  // R4: block-complete flag only from bus-controller mode
  p_blk_mode_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> ($past(mode) == 2'b00 && $past(msg_done)));

  // R10: halt rises only at a message end with stop-on-error set
  p_halt_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> ($past(msg_done) && $past(stop_on_err)));
endmodule

bind eom_irq_gen eomirq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode(mode),
  .msg_done(msg_done), .stop_on_err(stop_on_err), .irq_n(irq_n),
  .flags(flags), .halt_req(halt_req)
);

// File: tb/tb_eom_irq_gen.sv
module tb_eom_irq_gen;
  localparam int CW = 6;
  localparam logic [1:0] BC = 2'b00, MT = 2'b01, RT = 2'b10, RS = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic soft_rst = 1'b0;
  logic [1:0] mode = BC;
  logic msg_done = 1'b0;
  logic [3:0] err_vec = 4'h0;
  logic [CW-1:0] msg_count = '0;
  logic [2:0] mask = 3'b000;
  logic stop_on_err = 1'b0;
  logic flag_rd = 1'b0;
  logic irq_n;
  logic [2:0] flags;
  logic [3:0] cause;
  logic halt_req;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  eom_irq_gen #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode(mode),
    .msg_done(msg_done), .err_vec(err_vec), .msg_count(msg_count),
    .mask(mask), .stop_on_err(stop_on_err), .flag_rd(flag_rd),
    .irq_n(irq_n), .flags(flags), .cause(cause), .halt_req(halt_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // one message end; outputs checked by caller afterwards
  task automatic end_msg(input logic [1:0] md, input logic [3:0] e,
                         input logic [CW-1:0] cnt, input logic rd);
    mode = md; err_vec = e; msg_count = cnt; msg_done = 1'b1; flag_rd = rd;
    step();
    msg_done = 1'b0; err_vec = 4'h0; flag_rd = 1'b0;
  endtask

  task automatic clear_all();
    soft_rst = 1'b1; step(); soft_rst = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; step(); step();
    chk("R1 irq_n in reset", irq_n, 1); chk("R1 flags in reset", flags, 0);
    rst_n = 1'b1; step();
    chk("R1 irq_n idle", irq_n, 1); chk("R1 flags idle", flags, 0);
    chk("R1 cause idle", cause, 0); chk("R1 halt idle", halt_req, 0);
  endtask

  task automatic t_eom_basic();
    mask = 3'b001;
    end_msg(BC, 4'h0, 6'd3, 1'b0);
    chk("R2 bc eom flag", flags, 3'b001); chk("R6 bc pulse", irq_n, 0);
    step(); chk("R7 pulse ended", irq_n, 1);
    clear_all();
    end_msg(RT, 4'h0, 6'd0, 1'b0);
    chk("R2 rtu eom flag", flags, 3'b001); chk("R6 rtu pulse", irq_n, 0);
    clear_all();
  endtask

  task automatic t_fmt_sources();
    mask = 3'b010;
    for (int b = 0; b < 4; b++) begin
      end_msg(BC, 4'(1 << b), 6'd1, 1'b0);
      chk("R3 fmt flag strobe-cycle", flags, 3'b011);
      chk("R12 cause strobe-cycle", cause, 32'(1 << b));
      chk("R6 fmt pulse", irq_n, 0);
      clear_all();
      err_vec = 4'(1 << b); step(); err_vec = 4'h0; step();
      end_msg(RT, 4'h0, 6'd1, 1'b0);
      chk("R3 fmt flag early fault", flags, 3'b011);
      chk("R12 cause early fault", cause, 32'(1 << b));
      clear_all();
    end
  endtask

  task automatic t_pending_discard();
    mask = 3'b010;
    err_vec = 4'h4; step(); err_vec = 4'h0;
    end_msg(BC, 4'h0, 6'd1, 1'b0);
    chk("R11 first msg faulted", flags[1], 1);
    flag_rd = 1'b1; step(); flag_rd = 1'b0;
    end_msg(BC, 4'h0, 6'd1, 1'b0);
    chk("R11 clean msg no fmt", flags, 3'b001);
    chk("R11 clean msg no pulse", irq_n, 1);
    clear_all();
  endtask

  task automatic t_block();
    mask = 3'b100;
    end_msg(BC, 4'h0, 6'd62, 1'b0);
    chk("R4 count 62 no blk", flags, 3'b001); chk("R4 no blk pulse", irq_n, 1);
    end_msg(BC, 4'h0, 6'd63, 1'b0);
    chk("R4 count 63 blk", flags, 3'b101); chk("R4 blk pulse", irq_n, 0);
    clear_all();
    end_msg(RT, 4'h0, 6'd63, 1'b0);
    chk("R4 rtu suppresses blk", flags, 3'b001); chk("R4 rtu no pulse", irq_n, 1);
    clear_all();
  endtask

  task automatic t_silent_modes();
    mask = 3'b111; stop_on_err = 1'b1;
    end_msg(MT, 4'hF, 6'd63, 1'b0);
    chk("R5 mt no flags", flags, 0); chk("R5 mt no pulse", irq_n, 1);
    chk("R5 mt no halt", halt_req, 0); chk("R5 mt no cause", cause, 0);
    end_msg(RS, 4'h2, 6'd63, 1'b0);
    chk("R5 rsv no flags", flags, 0); chk("R5 rsv no pulse", irq_n, 1);
    stop_on_err = 1'b0;
    clear_all();
  endtask

  task automatic t_mask();
    mask = 3'b000;
    end_msg(BC, 4'h1, 6'd63, 1'b0);
    chk("R6 all masked no pulse", irq_n, 1);
    chk("R6 flags kept when masked", flags, 3'b111);
    clear_all();
    mask = 3'b100;
    end_msg(BC, 4'h1, 6'd5, 1'b0);
    chk("R6 unmatched enable no pulse", irq_n, 1);
    clear_all();
  endtask

  task automatic t_multi();
    mask = 3'b111;
    end_msg(BC, 4'h8, 6'd63, 1'b0);
    chk("R7 multi pulse low", irq_n, 0);
    step(); chk("R7 multi one clock", irq_n, 1);
    step(); chk("R7 stays high", irq_n, 1);
    clear_all();
  endtask

  task automatic t_read_clear();
    mask = 3'b000;
    end_msg(BC, 4'h2, 6'd63, 1'b0);
    step(); chk("R8 sticky", flags, 3'b111);
    flag_rd = 1'b1; step(); flag_rd = 1'b0;
    chk("R8 read clears flags", flags, 0); chk("R8 read clears cause", cause, 0);
    end_msg(BC, 4'h2, 6'd1, 1'b0);
    end_msg(BC, 4'h0, 6'd1, 1'b1);
    chk("R8 same-edge set wins", flags, 3'b001);
    chk("R8 same-edge cause cleared", cause, 0);
    clear_all();
  endtask

  task automatic t_soft();
    mask = 3'b111; stop_on_err = 1'b1;
    end_msg(BC, 4'h1, 6'd63, 1'b0);
    chk("R10 halt set", halt_req, 1);
    soft_rst = 1'b1;
    end_msg(BC, 4'h1, 6'd63, 1'b0);
    soft_rst = 1'b0;
    chk("R9 flags cleared", flags, 0); chk("R9 cause cleared", cause, 0);
    chk("R9 irq high", irq_n, 1); chk("R9 halt cleared", halt_req, 0);
    stop_on_err = 1'b0;
  endtask

  task automatic t_halt();
    mask = 3'b000; stop_on_err = 1'b1;
    end_msg(BC, 4'h0, 6'd1, 1'b0);
    chk("R10 clean msg no halt", halt_req, 0);
    end_msg(RT, 4'h4, 6'd1, 1'b0);
    chk("R10 masked fault halts", halt_req, 1);
    step(); step(); chk("R10 halt held", halt_req, 1);
    stop_on_err = 1'b0; step();
    chk("R10 halt drops with stop off", halt_req, 0);
    end_msg(BC, 4'h4, 6'd1, 1'b0);
    chk("R10 no halt when stop off", halt_req, 0);
    clear_all();
  endtask

  initial begin
    t_reset();
    t_eom_basic();
    t_fmt_sources();
    t_pending_discard();
    t_block();
    t_silent_modes();
    t_mask();
    t_multi();
    t_read_clear();
    t_soft();
    t_halt();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule